// File: doc/BRIEF.md
# RC Oscillator Period Capture Timer

This block measures the period of a slow, free-running RC oscillator against the fast crystal-derived system clock. Software uses the result to recalibrate the divider that turns the oscillator into a periodic tick. A 16-bit counter advances by one on every system clock. The capture input carries the RC oscillator divided by two, so it is asynchronous to the system clock. While capture is enabled, each falling edge of the synchronized input copies the counter into a capture register and sets a sticky flag.

The block also computes the difference between the two most recent captures. The subtraction is modulo 2^16, so a counter wrap between captures gives the right result. Because the capture input runs at half the oscillator rate, one difference spans two oscillator periods. The oscillator runs between 1 kHz and 5 kHz, and the system clock is much faster. A difference is marked valid only once two captures have been taken since capture was last enabled.

Top module: `rcPeriodCapture`

## Requirements
- R1: After a synchronous active-low reset, capHigh, capLow, diffValue, capFlag and diffValid are all zero, and the internal counter restarts at 0.
- R2: The counter increases by one on every clock and wraps from 0xFFFF to 0x0000. Captured values therefore advance by exactly the number of clocks between the capture edges.
- R3: When captureIn falls while captureEnable is high, the capture register loads the counter value at the third rising clock edge after the fall (two synchronizer stages followed by an edge detector).
- R4: A rising edge of captureIn never changes the capture register, capFlag, diffValue or diffValid.
- R5: While captureEnable is low, falling edges cause no capture. The capture register and capFlag keep their values.
- R6: capFlag is set on every capture and stays set until flagClear is sampled high. If a capture and flagClear occur on the same edge, the set wins.
- R7: On each capture that has a previous capture since enable, diffValue loads (new capture − previous capture) modulo 2^16 on the same edge as the capture register. It holds at other times.
- R8: diffValid is low after reset and goes low on the edge after captureEnable is sampled low. It rises only with the second capture after enable and stays high while enable stays high.
- R9: capHigh presents bits 15:8 of the capture register, and capLow presents bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal) clock |
| rstN | input | 1 | Synchronous active-low reset |
| captureEnable | input | 1 | Enables external capture |
| captureIn | input | 1 | Asynchronous divided-by-two RC oscillator |
| flagClear | input | 1 | Clears the capture flag |
| capHigh | output | 8 | Capture register upper byte |
| capLow | output | 8 | Capture register lower byte |
| capFlag | output | 1 | Sticky capture flag |
| diffValue | output | 16 | Difference of the last two captures |
| diffValid | output | 1 | diffValue holds a valid difference |

## Verification
The assertions check the following on every cycle:
- the capture register and flag hold while capture is disabled;
- the flag stays set until it is cleared;
- a clear with capture disabled empties the flag;
- diffValid drops after a disable;
- whenever the capture register moves while diffValid is high, diffValue equals the modular step of the captured value.

Only the bench's scenarios can show the rest, because the bench carries its own cycle count:
- the exact capture latency through the synchronizer against an absolute counter value;
- that rising edges are ignored;
- that the set wins over a simultaneous clear;
- the difference across a counter wrap.

// File: rtl/rcpcPkg.sv
package rcpcPkg;
  typedef struct packed {
    logic capture;   // load capture register, set flag
    logic loadDiff;  // load difference register
  } capStrobe_t;
endpackage

// File: rtl/rcpcControl.sv
module rcpcControl
  import rcpcPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit FALL_EDGE   = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       captureEnable,
  input  logic       captureIn,
  input  logic       flagClear,
  output capStrobe_t strobe,
  output logic       capFlag,
  output logic       diffValid
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          syncDelay;
  logic          edgeSeen;
  logic          havePrev;
  logic          flagQ;
  logic          validQ;

  // two-or-more flop synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      syncDelay <= 1'b0;
    end else begin
      syncChain <= {syncChain[LAST-1:0], captureIn};
      syncDelay <= syncChain[LAST];
    end
  end

  generate
    if (FALL_EDGE) begin : g_fall
      assign edgeSeen = syncDelay & ~syncChain[LAST];
    end else begin : g_rise
      assign edgeSeen = ~syncDelay & syncChain[LAST];
    end
  endgenerate

  always_comb begin
    strobe.capture  = captureEnable & edgeSeen;
    strobe.loadDiff = captureEnable & edgeSeen & havePrev;
  end

  // history of captures since enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev <= 1'b0;
    end else if (!captureEnable) begin
      havePrev <= 1'b0;
    end else if (strobe.capture) begin
      havePrev <= 1'b1;
    end
  end

  // sticky flag, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobe.capture) begin
      flagQ <= 1'b1;
    end else if (flagClear) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (!captureEnable) begin
      validQ <= 1'b0;
    end else if (strobe.loadDiff) begin
      validQ <= 1'b1;
    end
  end

  assign capFlag   = flagQ;
  assign diffValid = validQ;
endmodule

// File: rtl/rcpcDatapath.sv
module rcpcDatapath
  import rcpcPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  output logic [CNT_W-1:0] capValue,
  output logic [CNT_W-1:0] diffValue
);
  logic [CNT_W-1:0] counter;
  logic [CNT_W-1:0] capReg;
  logic [CNT_W-1:0] diffReg;
  logic [CNT_W-1:0] diffNext;

  always_ff @(posedge clk) begin
    if (!rstN) counter <= '0;
    else       counter <= counter + 1'b1;
  end

  // modulo-2^CNT_W subtraction
  assign diffNext = counter - capReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg  <= '0;
      diffReg <= '0;
    end else begin
      if (strobe.capture)  capReg  <= counter;
      if (strobe.loadDiff) diffReg <= diffNext;
    end
  end

  assign capValue  = capReg;
  assign diffValue = diffReg;
endmodule

// File: rtl/rcPeriodCapture.sv
module rcPeriodCapture
  import rcpcPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               captureEnable,
  input  logic               captureIn,
  input  logic               flagClear,
  output logic [CNT_W/2-1:0] capHigh,
  output logic [CNT_W/2-1:0] capLow,
  output logic               capFlag,
  output logic [CNT_W-1:0]   diffValue,
  output logic               diffValid
);
  localparam int HALF_W = CNT_W / 2;

  capStrobe_t       strobe;
  logic [CNT_W-1:0] capValue;

  rcpcControl #(.SYNC_STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) i_control (
    .clk(clk), .rstN(rstN), .captureEnable(captureEnable),
    .captureIn(captureIn), .flagClear(flagClear), .strobe(strobe),
    .capFlag(capFlag), .diffValid(diffValid)
  );

  rcpcDatapath #(.CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .capValue(capValue), .diffValue(diffValue)
  );

  assign capHigh = capValue[CNT_W-1:HALF_W];
  assign capLow  = capValue[HALF_W-1:0];
endmodule

// File: rtl/rcpcChecker.sv
module rcpcChecker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               captureEnable,
  input logic               flagClear,
  input logic [CNT_W/2-1:0] capHigh,
  input logic [CNT_W/2-1:0] capLow,
  input logic               capFlag,
  input logic [CNT_W-1:0]   diffValue,
  input logic               diffValid
);
  logic [CNT_W-1:0] capFull;
  assign capFull = {capHigh, capLow};

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !captureEnable |=> $stable(capFull)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    capFlag && !flagClear |=> capFlag); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flagClear && !captureEnable |=> !capFlag); // R6
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !captureEnable |=> !diffValid); // R8
  AST_DIFF_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (capFull != $past(capFull)) && diffValid |->
      diffValue == CNT_W'(capFull - $past(capFull))); // R7
endmodule

bind rcPeriodCapture rcpcChecker #(.CNT_W(CNT_W)) i_rcpcChecker (
  .clk(clk), .rstN(rstN), .captureEnable(captureEnable),
  .flagClear(flagClear), .capHigh(capHigh), .capLow(capLow),
  .capFlag(capFlag), .diffValue(diffValue), .diffValid(diffValid)
);

// File: tb/test_rcPeriodCapture.sv
module test_rcPeriodCapture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        captureEnable = 1'b0;
  logic        captureIn = 1'b0;
  logic        flagClear = 1'b0;
  logic [7:0]  capHigh, capLow;
  logic        capFlag, diffValid;
  logic [15:0] diffValue;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [15:0] modelCnt = '0;
  logic [15:0] expCap = '0, expDiff = '0, prevCap = '0;
  bit expFlag = 0, expValid = 0, havePrev = 0, enModel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) modelCnt <= rstN ? modelCnt + 16'd1 : 16'd0; // R2 model

  rcPeriodCapture i_rcPeriodCapture (
    .clk(clk), .rstN(rstN), .captureEnable(captureEnable),
    .captureIn(captureIn), .flagClear(flagClear),
    .capHigh(capHigh), .capLow(capLow), .capFlag(capFlag),
    .diffValue(diffValue), .diffValid(diffValid)
  );

  function automatic logic [15:0] modSub(input logic [15:0] a, input logic [15:0] b);
    return a - b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk({req, " capHigh R9"}, capHigh, expCap[15:8]);
    chk({req, " capLow R9"}, capLow, expCap[7:0]);
    chk({req, " capFlag"}, capFlag, expFlag);
    chk({req, " diffValue"}, diffValue, expDiff);
    chk({req, " diffValid"}, diffValid, expValid);
  endtask

  task automatic setEnable(input bit en);
    captureEnable = en;
    enModel = en;
    if (!en) begin havePrev = 0; expValid = 0; end
    @(negedge clk);
  endtask

  // hold captureIn high for highCycles, checking that nothing moves (R4)
  task automatic doRise(input int highCycles);
    captureIn = 1'b1;
    repeat (highCycles) @(negedge clk);
    checkAll("R4 rise ignored");
  endtask

  // fall, check capture three edges later (R3/R7/R8), hold low
  task automatic doFall(input int lowCycles, input bit clearAtEdge, input string req);
    logic [15:0] base;
    captureIn = 1'b0;
    base = modelCnt;
    repeat (2) @(negedge clk);
    if (clearAtEdge) flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
    if (enModel) begin
      expCap  = base + 16'd2;
      expFlag = 1;
      if (havePrev) begin
        expDiff  = modSub(expCap, prevCap);
        expValid = 1;
      end
      prevCap  = expCap;
      havePrev = 1;
    end
    checkAll(req);
    repeat (lowCycles - 3) @(negedge clk);
  endtask

  task automatic clearFlag();
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
    expFlag = 0;
    checkAll("R6 clear");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // disabled: falls do nothing (R5), diffValid stays low (R8)
    doRise(6);
    doFall(8, 0, "R5 disabled fall");

    setEnable(1);
    doRise(5);
    doFall(10, 0, "R8 first capture no diff");
    doRise(7);
    doFall(9, 0, "R7 R8 second capture");

    // constrained random oscillator periods (R2 R3 R7)
    for (int i = 0; i < 40; i++) begin
      doRise(4 + int'($urandom_range(0, 250)));
      doFall(4 + int'($urandom_range(0, 250)), 0, "R3 R7 random");
    end

    // clear, then capture coinciding with a clear (R6 set wins)
    clearFlag();
    doRise(6);
    doFall(6, 1, "R6 set wins");
    clearFlag();

    // disable drops diffValid, flag holds (R5 R8)
    setEnable(0);
    checkAll("R8 disable drops valid");
    doRise(6);
    doFall(6, 0, "R5 no capture disabled");
    setEnable(1);
    doRise(6);
    doFall(6, 0, "R8 first after reenable");
    doRise(6);
    doFall(6, 0, "R8 second after reenable");

    // counter wrap between captures (R2 R7)
    captureIn = 1'b1;
    while (modelCnt != 16'hFFE0) @(negedge clk);
    doFall(12, 0, "R2 before wrap");
    doRise(20);
    doFall(12, 0, "R2 R7 across wrap");

    // reset again mid-run (R1)
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expCap = '0; expDiff = '0; expFlag = 0; expValid = 0; havePrev = 0;
    @(negedge clk);
    checkAll("R1 reset again");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule